// File: doc/BRIEF.md
# Programmable Down-Counting System Tick Timer

This block is a 32-bit down-counting timer behind a small register port. One of several slow strobe inputs is chosen as its time base, then thinned by a prescaler and a power-of-two divider. Each resulting tick decrements the main count. When the count is zero, a tick either reloads it from a buffer register or leaves it parked at zero. A second counter tallies main-count reloads and raises a pending interrupt flag each time it runs out. Because the inverted main count always rises, software can use it as a wrapping timestamp.

Writes to the control register and to the two reload buffers do not act at once. They are held until the next pulse of the selected strobe input, which stands for an edge of the slow timer clock. Each of these registers has its own completion flag in the status register. Software polls that flag and clears it by writing a 1 before relying on the new value. Configuration writes act immediately, but only while the timer is stopped.

Top module: `sys_tick_timer`

## Requirements
- R1: The register offsets are: setup 0x00, control 0x04, main buffer 0x08, main count 0x0C, event buffer 0x18, event count 0x1C, status 0x20. After reset every register reads 0 and `irq_out` is low. A read issued in one cycle returns its data on `bus_rdata` after the next clock edge.
- R2: The setup register keeps only these fields: strobe select in bits 13:12, divider code in bits 10:8, prescaler in bits 5:0. All other bits read 0, so writing all ones reads back 0x373F.
- R3: A write to control, main buffer or event buffer takes effect on the next cycle in which the selected strobe input is high. In that same cycle it sets a status flag: bit 5 for control, bit 4 for the main buffer, bit 2 for the event buffer. A status read captured in the cycle of the write still shows the flag clear. Writing 1 to a flag clears it.
- R4: Control bit 0 runs the main count and bit 2 enables its reload. Bit 3 runs the event count and bit 5 enables its reload. Bit 1 copies the main buffer into the main count when the control write takes effect, and bit 4 does the same for the event counter. Bits 1 and 4 are not stored and read back 0.
- R5: While running with reload enabled and buffer B, the main count steps down by one per tick and follows the sequence B, B-1, …, 0, B. Without reload it stops at 0.
- R6: The bitwise inverse of the main count rises by exactly one per tick, modulo 2^32.
- R7: A write to the setup register is ignored while control bit 0 is set.
- R8: Strobe select s picks input `src_tick[s]`. The main count receives one tick per (prescaler+1)·2^min(code,4) pulses of that input, and divider codes above 4 act as 4.
- R9: Each main-count reload, while control bit 3 is set, steps the event counter. A step taken at zero with event reload enabled sets the pending flag (status bit 1) and reloads from the event buffer. With main buffer B and event buffer I, the pending flag is therefore raised once every (B+1)·(I+1) ticks.
- R10: The pending flag is set whether or not interrupts are enabled. `irq_out` equals pending AND status bit 0 AND status bit 6, registered one cycle later. Status bits 0 and 6 take the written value.
- R11: If the pending flag is set in the same cycle that software writes 1 to clear it, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Candidate time-base strobes, one per select code |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Two events can land in the same cycle: the event counter running out and setting the pending flag, and a software write that clears that flag. The bench measures the interrupt period from two successive rising edges of `irq_out`. It then leaves one interrupt uncleared and schedules a clear write so that it is captured exactly at the edge of the next expiry. That timing is known from the measured period. A status read afterwards must still show the flag set. A second clear one cycle later must leave it at 0, which shows that the earlier write was timed to collide rather than being ignored.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CFG  = 6'h00;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h04;
  localparam logic [ADDR_W-1:0] A_CBUF = 6'h08;
  localparam logic [ADDR_W-1:0] A_COBS = 6'h0C;
  localparam logic [ADDR_W-1:0] A_IBUF = 6'h18;
  localparam logic [ADDR_W-1:0] A_IOBS = 6'h1C;
  localparam logic [ADDR_W-1:0] A_STAT = 6'h20;

  localparam int CFG_SRC_LSB = 12;
  localparam int CFG_DIV_LSB = 8;
  localparam int CFG_PRE_LSB = 0;

  localparam int CT_RUN   = 0;
  localparam int CT_LOAD  = 1;
  localparam int CT_AUTO  = 2;
  localparam int CT_IRUN  = 3;
  localparam int CT_ILOAD = 4;
  localparam int CT_IAUTO = 5;

  localparam int ST_IEN   = 0;
  localparam int ST_PEND  = 1;
  localparam int ST_IDONE = 2;
  localparam int ST_CDONE = 4;
  localparam int ST_KDONE = 5;
  localparam int ST_XIE   = 6;

  localparam int WC_CTRL = 0;
  localparam int WC_CBUF = 1;
  localparam int WC_IBUF = 2;
  localparam int WC_N    = 3;
endpackage

// File: rtl/stt_tick_gen.sv
module stt_tick_gen #(
  parameter int SRC_W   = 2,
  parameter int PRE_W   = 6,
  parameter int DIV_W   = 3,
  parameter int DIV_MAX = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [(1<<SRC_W)-1:0] src_tick,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [DIV_W-1:0]   div_code,
  input  logic               run,
  output logic               slow_stb,
  output logic               tick
);
  localparam int DCNT_W = (DIV_MAX < 1) ? 1 : DIV_MAX;

  logic [PRE_W-1:0]  pre_cnt;
  logic [DCNT_W-1:0] div_cnt;
  logic [DCNT_W-1:0] div_mask;
  logic [DIV_W-1:0]  div_eff;
  logic              pre_pulse;

  assign slow_stb  = src_tick[src_sel];
  assign pre_pulse = run && slow_stb && (pre_cnt == prescale);

  always_comb begin
    div_eff  = (div_code > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : div_code;
    div_mask = DCNT_W'((32'd1 << div_eff) - 32'd1);
  end

  assign tick = pre_pulse && ((div_cnt & div_mask) == div_mask);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (slow_stb) begin
      pre_cnt <= pre_pulse ? '0 : pre_cnt + 1'b1;
      if (pre_pulse) div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stt_down_ctr.sv
module stt_down_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         auto,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         wrap
);
  assign wrap = step && !load && auto && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= reload;
    end else if (step) begin
      if (count != '0)  count <= count - 1'b1;
      else if (auto)    count <= reload;
    end
  end
endmodule

// File: rtl/stt_wr_commit.sv
module stt_wr_commit #(
  parameter int N  = 3,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         hit,
  input  logic [DW-1:0]        wdata,
  input  logic                 slow_stb,
  output logic [N-1:0]         commit,
  output logic [N-1:0][DW-1:0] data
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic          pend_r;
    logic [DW-1:0] data_r;

    assign commit[g] = slow_stb & pend_r;
    assign data[g]   = data_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_r <= 1'b0;
        data_r <= '0;
      end else if (hit[g]) begin
        pend_r <= 1'b1;
        data_r <= wdata;
      end else if (commit[g]) begin
        pend_r <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
  import stt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SRC_W = 2,
  parameter int PRE_W = 6,
  parameter int DIV_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<SRC_W)-1:0] src_tick,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  irq_out
);
  localparam logic [DW-1:0] CFG_MASK =
      DW'((((1 << SRC_W) - 1) << CFG_SRC_LSB) |
          (((1 << DIV_W) - 1) << CFG_DIV_LSB) |
          (((1 << PRE_W) - 1) << CFG_PRE_LSB));
  localparam logic [DW-1:0] CTRL_KEEP =
      DW'((1 << CT_RUN) | (1 << CT_AUTO) | (1 << CT_IRUN) | (1 << CT_IAUTO));
  localparam logic [DW-1:0] ST_EN_MASK   = DW'((1 << ST_IEN) | (1 << ST_XIE));
  localparam logic [DW-1:0] ST_FLAG_MASK =
      DW'((1 << ST_PEND) | (1 << ST_IDONE) | (1 << ST_CDONE) | (1 << ST_KDONE));

  logic wr, rd;
  logic [DW-1:0] cfg_q, ctrl_q, cbuf_q, ibuf_q, st_q, st_set;
  logic [WC_N-1:0] hit, commit;
  logic [WC_N-1:0][DW-1:0] cdata;
  logic slow_stb, tick;
  logic run, auto, irun, iauto;
  logic cnt_load, icnt_load, cnt_wrap, icnt_wrap;
  logic [DW-1:0] cnt, icnt;

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  assign hit[WC_CTRL] = wr && (bus_addr == A_CTRL);
  assign hit[WC_CBUF] = wr && (bus_addr == A_CBUF);
  assign hit[WC_IBUF] = wr && (bus_addr == A_IBUF);

  assign run   = ctrl_q[CT_RUN];
  assign auto  = ctrl_q[CT_AUTO];
  assign irun  = ctrl_q[CT_IRUN];
  assign iauto = ctrl_q[CT_IAUTO];

  assign cnt_load  = commit[WC_CTRL] && cdata[WC_CTRL][CT_LOAD];
  assign icnt_load = commit[WC_CTRL] && cdata[WC_CTRL][CT_ILOAD];

  stt_wr_commit #(.N(WC_N), .DW(DW)) u_commit (
    .clk(clk), .rst(rst), .hit(hit), .wdata(bus_wdata),
    .slow_stb(slow_stb), .commit(commit), .data(cdata)
  );

  stt_tick_gen #(.SRC_W(SRC_W), .PRE_W(PRE_W), .DIV_W(DIV_W), .DIV_MAX(4)) u_tick (
    .clk(clk), .rst(rst), .src_tick(src_tick),
    .src_sel(cfg_q[CFG_SRC_LSB +: SRC_W]),
    .prescale(cfg_q[CFG_PRE_LSB +: PRE_W]),
    .div_code(cfg_q[CFG_DIV_LSB +: DIV_W]),
    .run(run), .slow_stb(slow_stb), .tick(tick)
  );

  stt_down_ctr #(.W(DW)) u_main (
    .clk(clk), .rst(rst), .step(tick), .auto(auto), .load(cnt_load),
    .reload(cbuf_q), .count(cnt), .wrap(cnt_wrap)
  );

  stt_down_ctr #(.W(DW)) u_evt (
    .clk(clk), .rst(rst), .step(cnt_wrap && irun), .auto(iauto), .load(icnt_load),
    .reload(ibuf_q), .count(icnt), .wrap(icnt_wrap)
  );

  always_comb begin
    st_set = '0;
    st_set[ST_KDONE] = commit[WC_CTRL];
    st_set[ST_CDONE] = commit[WC_CBUF];
    st_set[ST_IDONE] = commit[WC_IBUF];
    st_set[ST_PEND]  = icnt_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      cbuf_q <= '0;
      ibuf_q <= '0;
      st_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      if (wr && (bus_addr == A_CFG) && !run) cfg_q <= bus_wdata & CFG_MASK;
      if (commit[WC_CTRL]) ctrl_q <= cdata[WC_CTRL] & CTRL_KEEP;
      if (commit[WC_CBUF]) cbuf_q <= cdata[WC_CBUF];
      if (commit[WC_IBUF]) ibuf_q <= cdata[WC_IBUF];
      if (wr && (bus_addr == A_STAT))
        st_q <= (bus_wdata & ST_EN_MASK) | (st_q & ST_FLAG_MASK & ~bus_wdata) | st_set;
      else
        st_q <= st_q | st_set;
      irq_out <= st_q[ST_PEND] && st_q[ST_IEN] && st_q[ST_XIE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (bus_addr)
        A_CFG:   bus_rdata <= cfg_q;
        A_CTRL:  bus_rdata <= ctrl_q;
        A_CBUF:  bus_rdata <= cbuf_q;
        A_COBS:  bus_rdata <= cnt;
        A_IBUF:  bus_rdata <= ibuf_q;
        A_IOBS:  bus_rdata <= icnt;
        A_STAT:  bus_rdata <= st_q;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_out,
  input logic [DW-1:0] st_q,
  input logic          run,
  input logic [DW-1:0] cfg_q,
  input logic [DW-1:0] cnt,
  input logic          auto,
  input logic          cnt_load,
  input logic          tick,
  input logic          icnt_wrap,
  input logic          ctrl_commit
);
  a_r10_irq_needs_cause: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(st_q[1] && st_q[0] && st_q[6]));

  a_r10_irq_follows_cause: assert property (@(posedge clk) disable iff (rst)
    (st_q[1] && st_q[0] && st_q[6]) |=> irq_out);

  a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(cfg_q));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !auto && !cnt_load) |=> (cnt == '0));

  a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r3_ctrl_flag: assert property (@(posedge clk) disable iff (rst)
    ctrl_commit |=> st_q[5]);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    icnt_wrap |=> st_q[1]);
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .st_q(st_q), .run(run),
  .cfg_q(cfg_q), .cnt(cnt), .auto(auto), .cnt_load(cnt_load), .tick(tick),
  .icnt_wrap(icnt_wrap), .ctrl_commit(commit[0])
);

// File: tb/test_sys_tick_timer.sv
module test_sys_tick_timer;
  localparam int CLK_P = 10;
  localparam logic [5:0] R_CFG = 6'h00, R_CTRL = 6'h04, R_CBUF = 6'h08,
                         R_COBS = 6'h0C, R_IBUF = 6'h18, R_IOBS = 6'h1C,
                         R_STAT = 6'h20;

  logic clk = 1'b0;
  logic rst;
  logic [3:0] src_tick;
  logic bus_valid, bus_write;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic irq_out;
  int cyc = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] en_sh = 32'h0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign src_tick = {2'b00, (cyc % 3 == 0), 1'b1};

  sys_tick_timer i_sys_tick_timer (
    .clk(clk), .rst(rst), .src_tick(src_tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d, output int c);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
    c = cyc;
  endtask

  task automatic wait_flag(input int b, input string req);
    logic [31:0] v; int c;
    v = '0;
    for (int i = 0; i < 400; i++) begin
      bus_rd(R_STAT, v, c);
      if (v[b]) break;
    end
    chk(req, {31'd0, v[b]}, 32'd1);
    bus_wr(R_STAT, en_sh | (32'd1 << b));
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    bus_wr(R_CTRL, v); wait_flag(5, "R3 control done flag");
  endtask
  task automatic set_cbuf(input logic [31:0] v);
    bus_wr(R_CBUF, v); wait_flag(4, "R3 main buffer done flag");
  endtask
  task automatic set_ibuf(input logic [31:0] v);
    bus_wr(R_IBUF, v); wait_flag(2, "R3 event buffer done flag");
  endtask

  task automatic wait_irq(input logic lvl, output int c);
    c = -1;
    for (int i = 0; i < 400; i++) begin
      if (irq_out === lvl) begin c = cyc; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1, v2;
    int c1, c2, t1, t2;
    rst = 1; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset values
    begin
      logic [5:0] regs [7];
      regs = '{R_CFG, R_CTRL, R_CBUF, R_COBS, R_IBUF, R_IOBS, R_STAT};
      for (int i = 0; i < 7; i++) begin
        bus_rd(regs[i], v, c1);
        chk("R1 reset register", v, 32'h0);
      end
    end
    chk("R1 reset irq", {31'd0, irq_out}, 32'd0);

    // R2: setup field mask
    bus_wr(R_CFG, 32'hFFFF_FFFF);
    bus_rd(R_CFG, v, c1); chk("R2 setup mask", v, 32'h0000_373F);
    bus_wr(R_CFG, 32'h0);
    bus_rd(R_CFG, v, c1); chk("R2 setup cleared", v, 32'h0);

    // R3: handshake timing and W1C
    bus_wr(R_CBUF, 32'd5);
    bus_rd(R_STAT, v, c1); chk("R3 flag not yet set", {31'd0, v[4]}, 32'd0);
    bus_rd(R_STAT, v, c1); chk("R3 flag set after strobe", {31'd0, v[4]}, 32'd1);
    bus_wr(R_STAT, 32'h10);
    bus_rd(R_STAT, v, c1); chk("R3 flag cleared by 1", {31'd0, v[4]}, 32'd0);
    bus_rd(R_CBUF, v, c1); chk("R3 buffer took value", v, 32'd5);

    // R4/R5: reload sweep
    for (int b = 0; b < 6; b++) begin
      set_ctrl(32'h0);
      set_cbuf(b);
      set_ctrl(32'h7);
      if (b == 0) begin
        bus_rd(R_CTRL, v, c1); chk("R4 control readback", v, 32'h5);
      end
      for (int g = 1; g <= 5; g++) begin
        longint m, e;
        bus_rd(R_COBS, v1, c1);
        repeat (g - 1) @(negedge clk);
        bus_rd(R_COBS, v2, c2);
        m = b + 1;
        e = ((longint'(v1) - (c2 - c1)) % m + m) % m;
        chk("R5 reload sequence", v2, 32'(e));
      end
    end

    // R5: without reload it stops at zero
    set_ctrl(32'h0);
    set_cbuf(32'd3);
    set_ctrl(32'h3);
    repeat (10) @(negedge clk);
    bus_rd(R_COBS, v, c1); chk("R5 stop at zero", v, 32'd0);
    repeat (5) @(negedge clk);
    bus_rd(R_COBS, v, c1); chk("R5 stays at zero", v, 32'd0);

    // R6: timestamp
    set_ctrl(32'h0);
    set_cbuf(32'hFFFF_FFFF);
    set_ctrl(32'h7);
    for (int g = 1; g <= 3; g++) begin
      bus_rd(R_COBS, v1, c1);
      repeat (g * 7) @(negedge clk);
      bus_rd(R_COBS, v2, c2);
      chk("R6 timestamp rise", (~v2) - (~v1), 32'(c2 - c1));
    end

    // R7: setup locked while running
    bus_wr(R_CFG, 32'h0000_1234);
    bus_rd(R_CFG, v, c1); chk("R7 setup ignored while running", v, 32'h0);

    // R8: strobe select, prescaler, divider
    for (int s = 0; s < 2; s++)
      for (int p = 0; p <= 2; p += 2)
        for (int d = 0; d <= 6; d += 2) begin
          int l, k, de;
          set_ctrl(32'h0);
          bus_wr(R_CFG, (s << 12) | (d << 8) | p);
          set_ctrl(32'h7);
          de = (d > 4) ? 4 : d;
          l = ((s == 1) ? 3 : 1) * (p + 1) * (1 << de);
          k = 2 * l;
          bus_rd(R_COBS, v1, c1);
          repeat (k - 1) @(negedge clk);
          bus_rd(R_COBS, v2, c2);
          chk("R8 tick rate", v1 - v2, 32'(k / l));
        end
    set_ctrl(32'h0);
    bus_wr(R_CFG, 32'h0);

    // R9/R10: event period
    en_sh = 32'h41;
    bus_wr(R_STAT, en_sh);
    for (int b = 1; b <= 3; b++)
      for (int i = 1; i <= 2; i++) begin
        set_ctrl(32'h0);
        set_cbuf(b);
        set_ibuf(i);
        set_ctrl(32'h3F);
        bus_wr(R_STAT, en_sh | 32'h2);
        wait_irq(1'b0, t1);
        wait_irq(1'b1, t1);
        bus_wr(R_STAT, en_sh | 32'h2);
        wait_irq(1'b0, t2);
        wait_irq(1'b1, t2);
        chk("R9 pending period", 32'(t2 - t1), 32'((b + 1) * (i + 1)));
      end
    bus_rd(R_CTRL, v, c1); chk("R4 control readback full", v, 32'h2D);

    // R10: pending without full enables
    en_sh = 32'h01;
    bus_wr(R_STAT, en_sh | 32'h2);
    repeat (20) @(negedge clk);
    bus_rd(R_STAT, v, c1); chk("R10 pending sets regardless", {31'd0, v[1]}, 32'd1);
    chk("R10 irq masked", {31'd0, irq_out}, 32'd0);

    // R11: set and clear in the same cycle (period 4: b=1, i=1)
    set_ctrl(32'h0);
    set_cbuf(32'd1);
    set_ibuf(32'd1);
    set_ctrl(32'h3F);
    en_sh = 32'h41;
    bus_wr(R_STAT, en_sh | 32'h2);
    wait_irq(1'b0, t1);
    wait_irq(1'b1, t1);
    repeat (2) @(negedge clk);
    bus_wr(R_STAT, en_sh | 32'h2);
    bus_rd(R_STAT, v, c1); chk("R11 set beats clear", {31'd0, v[1]}, 32'd1);
    bus_wr(R_STAT, en_sh | 32'h2);
    bus_rd(R_STAT, v, c1); chk("R11 later clear works", {31'd0, v[1]}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule